// File: doc/BRIEF.md
# Serial-Bus Eight-Channel Converter Code Bank

This block is the digital front end of an eight-channel digital-to-analog converter that is programmed over a two-wire I2C bus. It receives write frames only. SCL and SDA are oversampled on a faster system clock. The block drives an open-drain pull-down enable on SDA to acknowledge bytes, and it keeps one 8-bit code for each converter channel. The codes are presented in parallel to the analog resistor strings.

A frame has four parts: a start condition, a device address byte, a sub-address byte that picks the channel, and one data byte, followed by a stop condition. The device address has a fixed 4-bit prefix and three low bits that three strap pins set. Up to eight of these blocks can therefore share one bus. The stored code is the raw binary value that was received, because the analog level rises monotonically with the code.

Top module: `i2c_dac_bank`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every channel code reads zero and `sda_pull` is low.
- R2: The block acknowledges an address byte only when its first seven bits, MSB first, are `0101` followed by `cs_pins[2]`, `cs_pins[1]`, `cs_pins[0]`, and its last bit is 0. After any other address byte it drives no acknowledge for the rest of the frame, and no code changes.
- R3: An address byte that matches but ends in 1 (a read) is not acknowledged. No code changes, and the block waits for the next start.
- R4: The low four bits of the sub-address byte are a channel code. Codes 1 to 8 select channel 1 to 8, whose code appears on `ch_word[8*(k-1) +: 8]` for channel k. The upper four bits have no effect.
- R5: Channel codes 0 and 9 to 15 are still acknowledged, but the data byte that follows changes no channel code.
- R6: The data byte arrives MSB first and is stored unchanged into the selected channel.
- R7: `sda_pull` is high from the SCL falling edge after the eighth bit of an accepted byte until the next SCL falling edge, and low while data bits are on the bus.
- R8: A stop condition part way through the data byte aborts the frame, and no code changes.
- R9: A code changes only after all eight data bits have been received, only while that byte's acknowledge is being driven, and no more than one channel changes per frame.
- R10: A start that follows a stop after the minimum idle time begins a new frame, which is accepted normally.
- R11: A start part way through a byte discards the partial frame and restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| cs_pins | input | 3 | Strapped low address bits |
| sda_pull | output | 1 | Pull-down enable for SDA during an acknowledge |
| ch_word | output | 64 | Eight channel codes; channel k in bits 8*(k-1)+7 : 8*(k-1) |

## Verification
The bench uses the default parameters: eight channels and the `0101` prefix. The strap pins are set to `101`, so the address match is tested on pin values that are not all equal, and a one-bit change in the strap field is enough to make a mismatching address. Each bus quarter-period lasts ten system clocks. This leaves time after the three-stage synchronizer delay to sample the acknowledge window at its start, in its middle and after its release. It also allows a stop or a repeated start to be inserted between two bits of a byte.

// File: rtl/i2c_dac_pkg.sv
package i2c_dac_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 4;
    localparam int CS_W   = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SUB,
        PH_DATA,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(logic [BYTE_W-1:0] b, logic [CODE_W-1:0] prefix,
                                      logic [CS_W-1:0] cs);
        return (b[7:1] == {prefix, cs}) && !b[0];
    endfunction

    function automatic logic chan_ok(logic [CODE_W-1:0] c, int n);
        return (c != '0) && (int'(c) <= n);
    endfunction

    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_ADDR: return PH_SUB;
            PH_SUB:  return PH_DATA;
            default: return PH_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_dac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    // two-stage synchronizer plus one history stage per line
    logic [2:0] scl_p;
    logic [2:0] sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[1:0], scl_in};
            sda_p <= {sda_p[1:0], sda_in};
        end
    end

    logic scl_s, scl_q, sda_s, sda_q;
    assign scl_s = scl_p[1];
    assign scl_q = scl_p[2];
    assign sda_s = sda_p[1];
    assign sda_q = sda_p[2];

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_frame_rx.sv
module i2c_frame_rx
    import i2c_dac_pkg::*;
#(
    parameter int               NCH    = 8,
    parameter logic [CODE_W-1:0] PREFIX = 4'b0101
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [CS_W-1:0]   cs,
    output logic              ack,
    output logic              wr_en,
    output logic [CODE_W-1:0] wr_code,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    phase_e             phase;
    logic               in_ack;
    logic               ack_q;
    logic               wr_en_q;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [CODE_W-1:0]  sub_code;
    logic [BYTE_W-1:0]  wr_data_q;

    always_ff @(posedge clk) begin
        wr_en_q <= 1'b0;
        if (rst) begin
            phase     <= PH_IDLE;
            in_ack    <= 1'b0;
            ack_q     <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            sub_code  <= '0;
            wr_data_q <= '0;
        end else if (ev.start) begin
            phase  <= PH_ADDR;
            in_ack <= 1'b0;
            ack_q  <= 1'b0;
            cnt    <= '0;
        end else if (ev.stop) begin
            phase  <= PH_IDLE;
            in_ack <= 1'b0;
            ack_q  <= 1'b0;
            cnt    <= '0;
        end else if (phase != PH_IDLE) begin
            if (in_ack) begin
                if (ev.scl_fall) begin
                    in_ack <= 1'b0;
                    ack_q  <= 1'b0;
                    cnt    <= '0;
                    phase  <= next_phase(phase);
                end
            end else if (ev.scl_rise && cnt < CNT_W'(BYTE_W) && phase != PH_HOLD) begin
                shreg <= {shreg[BYTE_W-2:0], ev.sda};
                cnt   <= cnt + 1'b1;
            end else if (ev.scl_fall && cnt == CNT_W'(BYTE_W)) begin
                case (phase)
                    PH_ADDR: begin
                        if (addr_hit(shreg, PREFIX, cs)) begin
                            ack_q  <= 1'b1;
                            in_ack <= 1'b1;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    PH_SUB: begin
                        sub_code <= shreg[CODE_W-1:0];
                        ack_q    <= 1'b1;
                        in_ack   <= 1'b1;
                    end
                    PH_DATA: begin
                        wr_data_q <= shreg;
                        wr_en_q   <= chan_ok(sub_code, NCH);
                        ack_q     <= 1'b1;
                        in_ack    <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ack     = ack_q;
    assign wr_en   = wr_en_q;
    assign wr_code = sub_code;
    assign wr_data = wr_data_q;

endmodule

// File: rtl/dac_latch_bank.sv
module dac_latch_bank
    import i2c_dac_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CODE_W-1:0]     wr_code,
    input  logic [BYTE_W-1:0]     wr_data,
    output logic [NCH*BYTE_W-1:0] word
);
    logic [BYTE_W-1:0] lat [NCH];

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                lat[k] <= '0;
            else if (wr_en && wr_code == CODE_W'(k + 1))
                lat[k] <= wr_data;
        end
        assign word[k*BYTE_W +: BYTE_W] = lat[k];
    end

endmodule

// File: rtl/i2c_dac_bank.sv
module i2c_dac_bank
    import i2c_dac_pkg::*;
#(
    parameter int               NCH    = 8,
    parameter logic [CODE_W-1:0] PREFIX = 4'b0101
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic [2:0]            cs_pins,
    output logic                  sda_pull,
    output logic [NCH*8-1:0]      ch_word
);
    bus_ev_t           ev;
    logic              wr_en;
    logic [CODE_W-1:0] wr_code;
    logic [BYTE_W-1:0] wr_data;

    i2c_line_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_frame_rx #(.NCH(NCH), .PREFIX(PREFIX)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .cs      (cs_pins),
        .ack     (sda_pull),
        .wr_en   (wr_en),
        .wr_code (wr_code),
        .wr_data (wr_data)
    );

    dac_latch_bank #(.NCH(NCH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_code (wr_code),
        .wr_data (wr_data),
        .word    (ch_word)
    );

endmodule

// File: rtl/i2c_dac_bank_chk.sv
module i2c_dac_bank_chk #(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sda_pull,
    input logic [NCH*8-1:0] ch_word
);
    logic [NCH*8-1:0] prev_word;
    logic [NCH-1:0]   chg;

    always_ff @(posedge clk) begin
        if (rst) prev_word <= '0;
        else     prev_word <= ch_word;
    end

    for (genvar k = 0; k < NCH; k++) begin : g_chg
        assign chg[k] = ch_word[k*8 +: 8] != prev_word[k*8 +: 8];
    end

    // R1: reset clears every code
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (ch_word == '0));

    // R1: reset releases the data line
    a_r1_reset_release: assert property (@(posedge clk) rst |=> !sda_pull);

    // R9: at most one channel moves in any cycle
    a_r9_one_channel: assert property (@(posedge clk) disable iff (rst)
        $countones(chg) <= 1);

    // R9: a code only moves while the data byte is being acknowledged
    a_r9_write_in_ack: assert property (@(posedge clk) disable iff (rst)
        (chg != '0) |-> sda_pull);

endmodule

bind i2c_dac_bank i2c_dac_bank_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_pull (sda_pull),
    .ch_word  (ch_word)
);

// File: tb/sim_i2c_dac_bank.sv
module sim_i2c_dac_bank;

    localparam int NCH = 8;
    localparam int Q   = 10;
    localparam logic [2:0] CS = 3'b101;

    typedef struct {
        int         ch;
        logic [7:0] val;
        string      req;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_tb = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic [NCH*8-1:0] ch_word;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model [NCH];
    sb_item_t   sbq [$];
    bit         done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_tb & ~sda_pull;

    i2c_dac_bank u0 (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl),
        .sda_in   (sda_line),
        .cs_pins  (CS),
        .sda_pull (sda_pull),
        .ch_word  (ch_word)
    );

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected codes and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                sb_item_t it;
                it = sbq.pop_front();
                chk(ch_word[it.ch*8 +: 8] == it.val,
                    $sformatf("%s ch%0d", it.req, it.ch + 1),
                    64'(ch_word[it.ch*8 +: 8]), 64'(it.val));
            end
        end
    end

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic push_all(string req);
        for (int k = 0; k < NCH; k++) begin
            sb_item_t it;
            it.ch  = k;
            it.val = model[k];
            it.req = req;
            sbq.push_back(it);
        end
        wait (sbq.size() == 0);
        @(negedge clk);
    endtask

    task automatic bus_start();
        sda_tb = 1'b1; hq();
        scl = 1'b1;    hq();
        sda_tb = 1'b0; hq();
        scl = 1'b0;    hq();
    endtask

    task automatic bus_stop();
        sda_tb = 1'b0; hq();
        scl = 1'b1;    hq();
        sda_tb = 1'b1; hq(); hq();
    endtask

    task automatic send_bit(logic b);
        sda_tb = b; hq();
        scl = 1'b1; hq(); hq();
        scl = 1'b0; hq();
    endtask

    task automatic send_byte(logic [7:0] b, bit exp_ack, string req);
        logic p_pre, p_low, p_mid, p_post;
        for (int i = 7; i >= 1; i--) send_bit(b[i]);
        sda_tb = b[0]; hq();
        scl = 1'b1; hq();
        p_pre = sda_pull;
        hq();
        scl = 1'b0; hq();
        sda_tb = 1'b1;
        p_low = sda_pull;
        hq();
        scl = 1'b1; hq();
        p_mid = sda_pull;
        hq();
        scl = 1'b0; hq();
        p_post = sda_pull;
        // R7: window opens after the eighth bit and closes on the next fall
        chk(p_pre == 1'b0, {req, " R7 no pull on bit 8"}, 64'(p_pre), 64'(0));
        chk(p_low == exp_ack, {req, " R7 pull after 8th fall"}, 64'(p_low), 64'(exp_ack));
        chk(p_mid == exp_ack, {req, " ack on 9th clock"}, 64'(p_mid), 64'(exp_ack));
        chk(p_post == 1'b0, {req, " R7 release after 9th fall"}, 64'(p_post), 64'(0));
    endtask

    task automatic frame(logic [7:0] addr, logic [7:0] sub, logic [7:0] data, string req);
        bit acc;
        acc = (addr[7:1] == {4'b0101, CS}) && !addr[0];
        bus_start();
        send_byte(addr, acc, {req, " addr"});
        send_byte(sub, acc, {req, " sub"});
        send_byte(data, acc, {req, " data"});
        bus_stop();
        if (acc && sub[3:0] >= 4'd1 && sub[3:0] <= 4'd8)
            model[sub[3:0] - 1] = data;
        push_all(req);
    endtask

    localparam logic [7:0] AW = {4'b0101, CS, 1'b0};

    initial begin
        for (int k = 0; k < NCH; k++) model[k] = 8'h00;
        repeat (5) @(negedge clk);
        // R1: codes and pull during reset
        chk(ch_word == '0, "R1 codes in reset", 64'(ch_word), 64'(0));
        chk(sda_pull == 1'b0, "R1 pull in reset", 64'(sda_pull), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(ch_word == '0, "R1 codes after reset", 64'(ch_word), 64'(0));
        chk(sda_pull == 1'b0, "R1 pull after reset", 64'(sda_pull), 64'(0));
        hq();

        // R4 R6: every channel written with distinct raw codes
        for (int k = 1; k <= NCH; k++)
            frame(AW, 8'(k), 8'(8'h11 * k + 8'h80 * (k % 2)), "R4 R6 write");
        // R6: extreme codes
        frame(AW, 8'h01, 8'hFF, "R6 all ones");
        frame(AW, 8'h02, 8'h00, "R6 all zeros");
        // R4: upper nibble ignored
        frame(AW, 8'hA3, 8'h5A, "R4 upper nibble");
        // R2: wrong strap bits and wrong prefix
        frame({4'b0101, 3'b100, 1'b0}, 8'h04, 8'hEE, "R2 cs mismatch");
        frame({4'b0111, CS, 1'b0}, 8'h04, 8'hEE, "R2 prefix mismatch");
        // R3: read bit
        frame({4'b0101, CS, 1'b1}, 8'h05, 8'hDD, "R3 read bit");
        // R5: codes outside 1..8
        frame(AW, 8'h00, 8'hC3, "R5 code 0");
        frame(AW, 8'h09, 8'hC3, "R5 code 9");
        frame(AW, 8'h0F, 8'hC3, "R5 code 15");

        // R8: stop after four data bits
        bus_start();
        send_byte(AW, 1'b1, "R8 addr");
        send_byte(8'h02, 1'b1, "R8 sub");
        for (int i = 7; i >= 4; i--) send_bit(1'b1);
        bus_stop();
        push_all("R8 early stop");

        // R11: repeated start in the middle of the data byte
        bus_start();
        send_byte(AW, 1'b1, "R11 addr");
        send_byte(8'h06, 1'b1, "R11 sub");
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        frame(AW, 8'h07, 8'h3C, "R11 restart");

        // R10: back-to-back frames with minimal idle
        frame(AW, 8'h08, 8'h96, "R10 first");
        frame(AW, 8'h01, 8'h69, "R10 second");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule